// File: doc/BRIEF.md
# Stop-Synchronised Eight-Way I2C Channel Fan-Out

This block connects one upstream open-drain I2C pair to eight downstream pairs, modelled in digital logic as a wired-AND. Each physical line is represented by two signals. One is a pull-low request from each party. The other is the level that results once every connected pull is resolved. A channel whose bit is set in the active mask joins the upstream clock and data lines in both directions. A channel whose bit is clear is fully isolated.

A neighbouring register controller writes a new 8-bit selection word through a write strobe. The word is held as a pending value. It is copied into the active mask only when the neighbouring start/stop detector pulses its stop output. As a result, a channel is joined or split only while the bus lines are idle high. The active mask is also brought out as an output.

An asynchronous active-low reset disconnects every channel at once. Its release is synchronised to the clock.

Top module: `i2c_fab_switch`

## Requirements
- R1: While reset is held, and after its release before any stop pulse, the active mask is 0x00. All downstream and upstream drive outputs are 0.
- R2: A write strobe alone never changes the active mask. The new word waits, unchanged, until a stop pulse arrives.
- R3: A stop pulse copies the pending word into the active mask, visible after the next rising clock edge. A stop pulse with no new write reapplies the same word.
- R4: When the write strobe and the stop pulse occur in the same cycle, the word written in that cycle becomes active after that edge.
- R5: Bit n of the mask (bit 0 is the least significant) enables channel n. Any combination is allowed, including 0x00 and 0xFF.
- R6: The upstream drive output of a line is 1 exactly when at least one enabled channel's downstream party pulls that line low.
- R7: An enabled channel's downstream drive output is 1 whenever the resolved bus is low. The bus is low when the upstream host pulls the line or any enabled downstream party pulls it.
- R8: A disabled channel's drive output stays 0, and a pull by its downstream party has no effect on the upstream drive or the upstream level.
- R9: Asserting reset clears the active mask and every drive output without waiting for a clock edge. After release, the mask stays 0x00 for two edges, then writes and stops work again.
- R10: A level output reads 1 only when nothing connected to that line pulls it low. The upstream level is the inverse of the resolved bus. Each downstream level is low when its own party pulls it or when the block drives it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_wr_i | input | 1 | Strobe: capture sel_data_i as the pending word |
| sel_data_i | input | 8 | New channel selection word |
| stop_i | input | 1 | One-cycle pulse: a stop condition was seen upstream |
| host_scl_low_i | input | 1 | Upstream host pulls the clock line low |
| host_sda_low_i | input | 1 | Upstream host pulls the data line low |
| dn_scl_low_i | input | 8 | Downstream parties pull their clock lines low |
| dn_sda_low_i | input | 8 | Downstream parties pull their data lines low |
| up_scl_drive_o | output | 1 | Block pulls the upstream clock line low |
| up_sda_drive_o | output | 1 | Block pulls the upstream data line low |
| dn_scl_drive_o | output | 8 | Block pulls each downstream clock line low |
| dn_sda_drive_o | output | 8 | Block pulls each downstream data line low |
| up_scl_level_o | output | 1 | Resolved upstream clock level |
| up_sda_level_o | output | 1 | Resolved upstream data level |
| dn_scl_level_o | output | 8 | Resolved downstream clock levels |
| dn_sda_level_o | output | 8 | Resolved downstream data levels |
| active_mask_o | output | 8 | Channels currently connected |

## Verification
The two functions that can share a cycle are the capture of a new selection word and the stop pulse that commits the pending word. The bench raises sel_wr_i and stop_i together on one clock. It then requires the word written in that very cycle to appear on active_mask_o after that edge, not the previously pending value. A second collision is also covered: reset dropping while a full mask is connected and lines are pulled. There, every drive output must fall before the next edge.

// File: rtl/i2c_fab_pkg.sv
package i2c_fab_pkg;
  localparam int unsigned DEF_CH    = 8;
  localparam int unsigned LINE_CNT  = 2;
  typedef enum int unsigned {
    LINE_SCL = 0,
    LINE_SDA = 1
  } line_idx_e;
endpackage

// File: rtl/i2c_fab_rst_sync.sv
module i2c_fab_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/i2c_fab_selreg.sv
module i2c_fab_selreg #(
  parameter int unsigned NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [NUM_CH-1:0] data_i,
  input  logic              stop_i,
  output logic [NUM_CH-1:0] active_o
);
  logic [NUM_CH-1:0] pend_q, pend_d;
  logic [NUM_CH-1:0] act_q, act_d;
  logic              pend_en, act_en;

  always_comb begin
    pend_en = wr_i;
    pend_d  = data_i;
    act_en  = stop_i;
    // a word arriving with the stop is the one the stop closes
    act_d   = wr_i ? data_i : pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      act_q  <= '0;
    end else begin
      if (pend_en) pend_q <= pend_d;
      if (act_en)  act_q  <= act_d;
    end
  end

  assign active_o = act_q;

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_i |=> $stable(active_o));
  p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !wr_i) |=> (active_o == $past(pend_q)));
  p_fwd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && wr_i) |=> (active_o == $past(data_i)));
  p_rst_r1: assert property (@(posedge clk)
    !rst_n |-> (active_o == '0));
endmodule

// File: rtl/i2c_fab_lane.sv
module i2c_fab_lane #(
  parameter int unsigned NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] en_i,
  input  logic              host_low_i,
  input  logic [NUM_CH-1:0] dn_low_i,
  output logic              up_drive_o,
  output logic [NUM_CH-1:0] dn_drive_o,
  output logic              up_level_o,
  output logic [NUM_CH-1:0] dn_level_o
);
  logic [NUM_CH-1:0] tap;
  logic              bus_low;

  always_comb begin
    tap     = en_i & dn_low_i;
    bus_low = host_low_i | (|tap);
  end

  assign up_drive_o = |tap;
  assign up_level_o = ~bus_low;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign dn_drive_o[c] = en_i[c] & bus_low;
    assign dn_level_o[c] = ~(dn_low_i[c] | dn_drive_o[c]);
  end

  p_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !up_level_o |-> ((dn_drive_o | ~en_i) == {NUM_CH{1'b1}}));
  p_iso_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((dn_drive_o & ~en_i) == '0));
  p_dnlvl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((dn_level_o & dn_drive_o) == '0));
  p_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
    up_drive_o |-> !up_level_o);
endmodule

// File: rtl/i2c_fab_switch.sv
module i2c_fab_switch
  import i2c_fab_pkg::*;
#(
  parameter int unsigned NUM_CH = DEF_CH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_wr_i,
  input  logic [NUM_CH-1:0] sel_data_i,
  input  logic              stop_i,
  input  logic              host_scl_low_i,
  input  logic              host_sda_low_i,
  input  logic [NUM_CH-1:0] dn_scl_low_i,
  input  logic [NUM_CH-1:0] dn_sda_low_i,
  output logic              up_scl_drive_o,
  output logic              up_sda_drive_o,
  output logic [NUM_CH-1:0] dn_scl_drive_o,
  output logic [NUM_CH-1:0] dn_sda_drive_o,
  output logic              up_scl_level_o,
  output logic              up_sda_level_o,
  output logic [NUM_CH-1:0] dn_scl_level_o,
  output logic [NUM_CH-1:0] dn_sda_level_o,
  output logic [NUM_CH-1:0] active_mask_o
);
  logic              srst_n;
  logic [NUM_CH-1:0] act;
  logic [NUM_CH-1:0] en_gated;

  logic [LINE_CNT-1:0]             host_low;
  logic [LINE_CNT-1:0][NUM_CH-1:0] dn_low;
  logic [LINE_CNT-1:0]             up_drive, up_level;
  logic [LINE_CNT-1:0][NUM_CH-1:0] dn_drive, dn_level;

  i2c_fab_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  i2c_fab_selreg #(.NUM_CH(NUM_CH)) u_sel (
    .clk      (clk),
    .rst_n    (srst_n),
    .wr_i     (sel_wr_i),
    .data_i   (sel_data_i),
    .stop_i   (stop_i),
    .active_o (act)
  );

  // raw reset gates the paths so disconnection does not wait for a clock
  assign en_gated = rst_n ? act : '0;

  assign host_low[LINE_SCL] = host_scl_low_i;
  assign host_low[LINE_SDA] = host_sda_low_i;
  assign dn_low[LINE_SCL]   = dn_scl_low_i;
  assign dn_low[LINE_SDA]   = dn_sda_low_i;

  for (genvar l = 0; l < LINE_CNT; l++) begin : g_line
    i2c_fab_lane #(.NUM_CH(NUM_CH)) u_lane (
      .clk        (clk),
      .rst_n      (srst_n),
      .en_i       (en_gated),
      .host_low_i (host_low[l]),
      .dn_low_i   (dn_low[l]),
      .up_drive_o (up_drive[l]),
      .dn_drive_o (dn_drive[l]),
      .up_level_o (up_level[l]),
      .dn_level_o (dn_level[l])
    );
  end

  assign up_scl_drive_o = up_drive[LINE_SCL];
  assign up_sda_drive_o = up_drive[LINE_SDA];
  assign dn_scl_drive_o = dn_drive[LINE_SCL];
  assign dn_sda_drive_o = dn_drive[LINE_SDA];
  assign up_scl_level_o = up_level[LINE_SCL];
  assign up_sda_level_o = up_level[LINE_SDA];
  assign dn_scl_level_o = dn_level[LINE_SCL];
  assign dn_sda_level_o = dn_level[LINE_SDA];
  assign active_mask_o  = en_gated;

  p_rstoff_r9: assert property (@(posedge clk)
    !rst_n |-> (dn_scl_drive_o == '0 && dn_sda_drive_o == '0 &&
                !up_scl_drive_o && !up_sda_drive_o));
endmodule

// File: tb/i2c_fab_switch_bench.sv
`timescale 1ns/100ps
module i2c_fab_switch_bench;
  localparam int N = 8;
  logic clk = 1'b0;
  logic rst_n, sel_wr, stop, h_scl, h_sda;
  logic [N-1:0] sel_data, d_scl, d_sda;
  logic u_scl_dr, u_sda_dr, u_scl_lv, u_sda_lv;
  logic [N-1:0] n_scl_dr, n_sda_dr, n_scl_lv, n_sda_lv, amask;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  i2c_fab_switch u_i2c_fab_switch (
    .clk(clk), .rst_n(rst_n), .sel_wr_i(sel_wr), .sel_data_i(sel_data),
    .stop_i(stop), .host_scl_low_i(h_scl), .host_sda_low_i(h_sda),
    .dn_scl_low_i(d_scl), .dn_sda_low_i(d_sda),
    .up_scl_drive_o(u_scl_dr), .up_sda_drive_o(u_sda_dr),
    .dn_scl_drive_o(n_scl_dr), .dn_sda_drive_o(n_sda_dr),
    .up_scl_level_o(u_scl_lv), .up_sda_level_o(u_sda_lv),
    .dn_scl_level_o(n_scl_lv), .dn_sda_level_o(n_sda_lv),
    .active_mask_o(amask)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // independent wired-AND reference for one line
  task automatic ref_line(input string tag, input logic [N-1:0] m, input logic h,
                          input logic [N-1:0] d, input logic udr, input logic [N-1:0] ndr,
                          input logic ulv, input logic [N-1:0] nlv);
    logic any_dn, bus;
    logic [N-1:0] edr, elv;
    any_dn = 1'b0;
    for (int c = 0; c < N; c++) if (m[c] && d[c]) any_dn = 1'b1;
    bus = h | any_dn;
    for (int c = 0; c < N; c++) begin
      edr[c] = m[c] && bus;
      elv[c] = !(d[c] || edr[c]);
    end
    chk({tag, " R6 up drive"}, {31'd0, udr}, {31'd0, any_dn});
    chk({tag, " R7/R8 dn drive"}, {24'd0, ndr}, {24'd0, edr});
    chk({tag, " R10 up level"}, {31'd0, ulv}, {31'd0, !bus});
    chk({tag, " R10 dn level"}, {24'd0, nlv}, {24'd0, elv});
  endtask

  task automatic commit(input logic [N-1:0] w);
    @(negedge clk); sel_wr = 1'b1; sel_data = w;
    @(negedge clk); sel_wr = 1'b0; stop = 1'b1;
    @(negedge clk); stop = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; sel_wr = 0; stop = 0; sel_data = '0;
    h_scl = 0; h_sda = 0; d_scl = '1; d_sda = '1;
    repeat (3) @(negedge clk);
    chk("R1 mask in reset", {24'd0, amask}, 32'h0);
    chk("R1 drives in reset", {14'd0, u_scl_dr, u_sda_dr, n_scl_dr, n_sda_dr}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 mask after release", {24'd0, amask}, 32'h0);
    d_scl = '0; d_sda = '0;
  endtask

  task automatic t_defer();
    @(negedge clk); sel_wr = 1'b1; sel_data = 8'hA5;
    @(negedge clk); sel_wr = 1'b0;
    repeat (3) @(negedge clk);
    chk("R2 write held pending", {24'd0, amask}, 32'h0);
    stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    chk("R3 stop commits", {24'd0, amask}, 32'hA5);
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    chk("R3 bare stop reapplies", {24'd0, amask}, 32'hA5);
  endtask

  task automatic t_same_cycle();
    @(negedge clk); sel_wr = 1'b1; sel_data = 8'h3C;
    @(negedge clk); sel_wr = 1'b1; sel_data = 8'hC3; stop = 1'b1;
    @(negedge clk); sel_wr = 1'b0; stop = 1'b0;
    chk("R4 write with stop", {24'd0, amask}, 32'hC3);
  endtask

  task automatic t_each_bit();
    for (int b = 0; b < N; b++) begin
      commit(8'(1 << b));
      chk("R5 single bit mask", {24'd0, amask}, 32'(1 << b));
      d_scl = 8'(1 << b); d_sda = '0; h_scl = 0; h_sda = 0; #1;
      chk("R5 bit maps to channel", {24'd0, n_scl_dr}, 32'(1 << b));
      d_scl = '0;
    end
    commit(8'hFF); chk("R5 all channels", {24'd0, amask}, 32'hFF);
    commit(8'h00); chk("R5 no channel", {24'd0, amask}, 32'h00);
    d_scl = '1; d_sda = '1; #1;
    chk("R8 none enabled upstream idle", {30'd0, u_scl_dr, u_sda_dr}, 32'h0);
    d_scl = '0; d_sda = '0;
  endtask

  task automatic t_wired_random();
    logic [N-1:0] m;
    for (int i = 0; i < 40; i++) begin
      m = 8'($urandom);
      commit(m);
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        h_scl = 1'($urandom); h_sda = 1'($urandom);
        d_scl = 8'($urandom) & 8'($urandom); d_sda = 8'($urandom) & 8'($urandom);
        #1;
        ref_line("scl", m, h_scl, d_scl, u_scl_dr, n_scl_dr, u_scl_lv, n_scl_lv);
        ref_line("sda", m, h_sda, d_sda, u_sda_dr, n_sda_dr, u_sda_lv, n_sda_lv);
      end
    end
    h_scl = 0; h_sda = 0; d_scl = '0; d_sda = '0;
  endtask

  task automatic t_async_reset();
    commit(8'hFF);
    @(negedge clk); h_scl = 1'b1; d_sda = 8'h10;
    #0.5; rst_n = 1'b0; #0.5;
    chk("R9 mask cleared at once", {24'd0, amask}, 32'h0);
    chk("R9 drives cleared at once", {14'd0, u_scl_dr, u_sda_dr, n_scl_dr, n_sda_dr}, 32'h0);
    @(negedge clk); rst_n = 1'b1; h_scl = 0; d_sda = '0;
    sel_wr = 1'b1; sel_data = 8'h81; stop = 1'b1;
    @(negedge clk); sel_wr = 1'b0; stop = 1'b0;
    chk("R9 held off during release", {24'd0, amask}, 32'h0);
    @(negedge clk);
    commit(8'h81);
    chk("R9 operation after release", {24'd0, amask}, 32'h81);
  endtask

  initial begin
    void'($urandom(32'd7));
    t_reset();
    t_defer();
    t_same_cycle();
    t_each_bit();
    t_wired_random();
    t_async_reset();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule